// File: doc/BRIEF.md
# Isolated Gate Command Link with Refresh Watchdog

This block carries a single on/off gate command across a one-bit channel that models an isolation barrier. A sending half sits on the controller side and a receiving half on the power side. The sending half transmits the command as soon as it changes. It also repeats the command at a fixed interval when nothing changes, so a symbol that is lost in transit is made good by the next repeat.

The receiving half decodes each symbol and applies the command to the gate drive. It also counts the time since the last well-formed symbol. If the channel goes silent or carries only garbage for too long, the gate is forced off and a link-error flag is raised. That flag, together with the controller-side supply status, drives the ready output. The link error is cleared only after a run of consecutive good symbols.

When the controller-side supply falls, the sending half emits one last off symbol and then stays silent until the supply returns.

Top module: `gate_cmd_link`

## Requirements
- R1: A symbol occupies three consecutive cycles on `link_tx`: a 1 (start), then the command bit (1 = gate on, 0 = gate off), then a 0 (stop). Outside symbols the line is 0.
- R2: With supply good and an unchanged command, symbols begin every REFRESH_CYC cycles (default 10).
- R3: A change of the effective command (`cmd_req` AND `supply_ok`) starts a symbol at the first clock edge at which the line is idle, without waiting for the refresh interval. From an idle line, `gate_on` follows the change after exactly 4 clock edges, for both the on and the off direction.
- R4: If TIMEOUT_CYC cycles (default 40) pass without a well-formed symbol, `link_err` rises on the 40th edge after the last good one, `gate_on` goes low and `ready` goes low.
- R5: A malformed symbol, meaning a start and a command bit followed by a 1 where the stop should be, is dropped. It changes neither `gate_on` nor the timeout count.
- R6: When `supply_ok` falls, `ready` drops at once and one off symbol (1,0,0) starts on the next edge. After that, `link_tx` stays 0 while the supply stays low. When `supply_ok` returns, a symbol starts on the next edge.
- R7: `link_err` clears only after CLEAR_CNT (default 2) consecutive well-formed symbols, where a malformed symbol or a timeout restarts the count. After it clears, `gate_on` follows the received command again.
- R8: During reset, `gate_on` and `link_tx` are 0, `link_err` is 1 and `ready` is 0.
- R9: If a turn-on symbol is lost, the gate turns on from the next refresh symbol, at most one refresh period later than normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_req | input | 1 | Requested gate state from the controller, 1 = on |
| supply_ok | input | 1 | Controller-side supply above its lockout level |
| link_tx | output | 1 | Serial symbol stream driven into the barrier |
| link_rx | input | 1 | Serial symbol stream arriving from the barrier |
| gate_on | output | 1 | Gate drive command on the power side |
| link_err | output | 1 | Link timeout flag, 1 = no trusted command |
| ready | output | 1 | Supply good and link trusted |

## Verification
A wrong decoder phase shows up within four edges of a symbol: the gate either takes a bit it should have dropped or misses a change. A timeout counter that resets on bad symbols, or never saturates, shows up as `link_err` rising late or never during a stream of malformed frames. A faulty clear count shows up as `ready` returning after one good symbol instead of two. On the sending side, a wrong refresh counter or priority logic shows directly on `link_tx` as a wrong start spacing or a late start after a command change.

// File: rtl/gate_link_pkg.sv
// Shared phase encodings for the sending and receiving halves of the command link.
package gate_link_pkg;
    // Sender phase: which part of a symbol the line carries now.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HEAD = 2'd1,
        TX_BODY = 2'd2
    } tx_phase_t;

    // Receiver phase: which part of a symbol the next sample is expected to be.
    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_BIT  = 2'd1,
        RX_STOP = 2'd2
    } rx_phase_t;
endpackage

// File: rtl/link_sender.sv
// Sending half. Serialises the effective gate command as start/bit/stop symbols.
// Sends on every change, repeats every REFRESH_CYC cycles, and issues one off
// symbol when the supply drops, then stays silent.
// Assumes cmd_req and supply_ok are already synchronous to clk.
module link_sender
    import gate_link_pkg::*;
#(
    parameter int REFRESH_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_req,
    input  logic supply_ok,
    output logic line_out
);
    localparam int SW = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
    localparam logic [SW-1:0] DUE_AT = SW'(REFRESH_CYC - 1);

    tx_phase_t     phase;
    logic [SW-1:0] since;
    logic          last_sent;
    logic          sup_q;
    logic          bye_pend;
    logic          eff;
    logic          drop;
    logic          wake;
    logic          due;
    logic          want;
    logic          start;

    // Decide whether a symbol should begin on this edge.
    always_comb begin
        eff   = cmd_req & supply_ok;
        drop  = sup_q & ~supply_ok;
        wake  = ~sup_q & supply_ok;
        due   = (since == DUE_AT);
        want  = supply_ok ? ((eff != last_sent) | due | wake) : (bye_pend | drop);
        start = (phase == TX_IDLE) & want;
    end

    // Remember the previous supply state to see edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sup_q <= 1'b0;
        else        sup_q <= supply_ok;
    end

    // Hold a farewell request until its symbol can start.
    always_ff @(posedge clk) begin
        if (!rst_n)     bye_pend <= 1'b0;
        else if (start) bye_pend <= 1'b0;
        else if (drop)  bye_pend <= 1'b1;
    end

    // Count cycles since the last symbol start, saturating at the due point.
    always_ff @(posedge clk) begin
        if (!rst_n)     since <= '0;
        else if (start) since <= '0;
        else if (!due)  since <= since + SW'(1);
    end

    // Walk the symbol phases and drive the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= TX_IDLE;
            line_out  <= 1'b0;
            last_sent <= 1'b0;
        end else begin
            case (phase)
                TX_IDLE: begin
                    if (start) begin
                        phase    <= TX_HEAD;
                        line_out <= 1'b1;
                    end
                end
                TX_HEAD: begin
                    phase     <= TX_BODY;
                    line_out  <= eff;
                    last_sent <= eff;
                end
                default: begin
                    phase    <= TX_IDLE;
                    line_out <= 1'b0;
                end
            endcase
        end
    end

    // R3: a command change seen on an idle line starts a symbol on the next edge.
    assert_change_sent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == TX_IDLE && supply_ok && eff != last_sent) |=> line_out);

    // R6: with the supply down and the farewell already sent, the line stays low.
    assert_quiet_when_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && !bye_pend && !drop && phase == TX_IDLE) |=> !line_out);
endmodule

// File: rtl/link_receiver.sv
// Receiving half, framing part. Hunts for a start, captures the command bit and
// classifies the stop sample: 0 gives a one-cycle good strobe, 1 a bad strobe.
// A bad stop sample is not taken as a new start.
module link_receiver
    import gate_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic sym_ok,
    output logic sym_bad,
    output logic sym_cmd
);
    rx_phase_t phase;
    logic      bit_q;

    // Advance through hunt, bit and stop samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= RX_HUNT;
            bit_q <= 1'b0;
        end else begin
            case (phase)
                RX_HUNT: if (line_in) phase <= RX_BIT;
                RX_BIT: begin
                    bit_q <= line_in;
                    phase <= RX_STOP;
                end
                default: phase <= RX_HUNT;
            endcase
        end
    end

    // Classify the stop sample in the cycle it is seen.
    always_comb begin
        sym_ok  = (phase == RX_STOP) & ~line_in;
        sym_bad = (phase == RX_STOP) & line_in;
        sym_cmd = bit_q;
    end
endmodule

// File: rtl/link_monitor.sv
// Receiving half, trust part. Applies good commands, times out silence, and
// clears the error only after CLEAR_CNT consecutive good symbols.
// Starts in the error state so the gate stays off until the link is proven.
module link_monitor #(
    parameter int TIMEOUT_CYC = 40,
    parameter int CLEAR_CNT   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_ok,
    input  logic sym_bad,
    input  logic sym_cmd,
    output logic gate_on,
    output logic link_err
);
    localparam int QW = $clog2(TIMEOUT_CYC);
    localparam int GW = $clog2(CLEAR_CNT + 1);
    localparam logic [QW-1:0] QUIET_LIM = QW'(TIMEOUT_CYC - 1);
    localparam logic [GW-1:0] GOOD_LIM  = GW'(CLEAR_CNT - 1);

    logic [QW-1:0] quiet_cnt;
    logic [GW-1:0] good_cnt;
    logic          cmd_q;
    logic          expired;

    // Timeout is reached when the quiet count sits at its limit with no good symbol.
    always_comb expired = (quiet_cnt == QUIET_LIM) & ~sym_ok;

    // Count cycles since the last good symbol; bad symbols do not reset it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    quiet_cnt <= '0;
        else if (sym_ok)               quiet_cnt <= '0;
        else if (quiet_cnt != QUIET_LIM) quiet_cnt <= quiet_cnt + QW'(1);
    end

    // Hold the last good command.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= 1'b0;
        else if (sym_ok) cmd_q <= sym_cmd;
    end

    // Raise the error on timeout; clear it after a run of good symbols.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_err <= 1'b1;
            good_cnt <= '0;
        end else if (sym_ok) begin
            if (link_err) begin
                if (good_cnt == GOOD_LIM) begin
                    link_err <= 1'b0;
                    good_cnt <= '0;
                end else begin
                    good_cnt <= good_cnt + GW'(1);
                end
            end
        end else if (sym_bad || expired) begin
            good_cnt <= '0;
            if (expired) link_err <= 1'b1;
        end
    end

    // The gate follows the command only while the link is trusted.
    always_comb gate_on = cmd_q & ~link_err;

    // R4: a full quiet window without a good symbol raises the error.
    assert_timeout_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt == QUIET_LIM && !sym_ok) |=> link_err);

    // R5: a malformed symbol does not restart the quiet window.
    assert_bad_keeps_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_bad && quiet_cnt != QUIET_LIM) |=> quiet_cnt == $past(quiet_cnt) + QW'(1));

    // R7: the error only clears on the edge of a good symbol.
    assert_clear_on_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_err) |-> $past(sym_ok));
endmodule

// File: rtl/gate_cmd_link.sv
// Top of the command link: sender, receiver framing and trust monitor.
// The barrier itself lies outside: link_tx leaves, link_rx returns.
// ready combines the controller-side supply status with link trust.
module gate_cmd_link #(
    parameter int REFRESH_CYC = 10,
    parameter int TIMEOUT_CYC = 40,
    parameter int CLEAR_CNT   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_req,
    input  logic supply_ok,
    output logic link_tx,
    input  logic link_rx,
    output logic gate_on,
    output logic link_err,
    output logic ready
);
    logic sym_ok;
    logic sym_bad;
    logic sym_cmd;

    link_sender #(.REFRESH_CYC(REFRESH_CYC)) u_send (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_req  (cmd_req),
        .supply_ok(supply_ok),
        .line_out (link_tx)
    );

    link_receiver u_recv (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(link_rx),
        .sym_ok (sym_ok),
        .sym_bad(sym_bad),
        .sym_cmd(sym_cmd)
    );

    link_monitor #(.TIMEOUT_CYC(TIMEOUT_CYC), .CLEAR_CNT(CLEAR_CNT)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_ok  (sym_ok),
        .sym_bad (sym_bad),
        .sym_cmd (sym_cmd),
        .gate_on (gate_on),
        .link_err(link_err)
    );

    // Ready reports a good supply and a trusted link.
    always_comb ready = supply_ok & ~link_err;

    // R4: an untrusted link never leaves the gate on.
    assert_err_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_err) |-> !gate_on);
endmodule

// File: tb/tb_gate_cmd_link.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_gate_cmd_link;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_req = 1'b0;
    logic supply_ok = 1'b0;
    logic link_tx;
    logic link_rx;
    logic gate_on;
    logic link_err;
    logic ready;
    logic kill = 1'b0;
    logic man_en = 1'b0;
    logic man_bit = 1'b0;
    int   checks = 0;
    int   fails = 0;

    always #4 clk = ~clk;

    // The barrier: pass-through, a loss window, or bench-driven symbols.
    assign link_rx = man_en ? man_bit : (link_tx & ~kill);

    gate_cmd_link dut (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .supply_ok(supply_ok),
        .link_tx(link_tx), .link_rx(link_rx), .gate_on(gate_on),
        .link_err(link_err), .ready(ready)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for a start on link_tx, then two more cycles: the sender is idle after that.
    task automatic align_idle();
        logic prev;
        prev = link_tx;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!prev && link_tx) begin
                step(2);
                return;
            end
            prev = link_tx;
        end
        chk("R2", "no symbol start found", 1'b0, 1'b1);
    endtask

    // Drive three bench symbol cycles followed by one idle cycle.
    task automatic send_sym(input logic a, input logic b, input logic c);
        man_bit = a; step(1);
        man_bit = b; step(1);
        man_bit = c; step(1);
        man_bit = 1'b0; step(1);
    endtask

    task automatic t_reset();
        step(5);
        chk("R8", "gate_on in reset", gate_on, 1'b0);
        chk("R8", "link_err in reset", link_err, 1'b1);
        chk("R8", "ready in reset", ready, 1'b0);
        chk("R8", "link_tx in reset", link_tx, 1'b0);
    endtask

    task automatic t_linkup();
        supply_ok = 1'b1;
        rst_n = 1'b1;
        step(40);
        chk("R7", "link_err after startup symbols", link_err, 1'b0);
        chk("R7", "ready after startup symbols", ready, 1'b1);
    endtask

    task automatic t_frame();
        logic prev;
        int   period;
        align_idle();
        // Now two cycles after a start; find the following start and its spacing.
        prev = link_tx;
        period = 0;
        for (int j = 1; j <= 30 && period == 0; j++) begin
            @(negedge clk);
            if (!prev && link_tx) period = j + 2;
            prev = link_tx;
        end
        chk("R2", "refresh spacing is 10", 1'(period == 10), 1'b1);
        chk("R1", "start bit", link_tx, 1'b1);
        step(1);
        chk("R1", "command bit (off)", link_tx, 1'b0);
        step(1);
        chk("R1", "stop bit", link_tx, 1'b0);
    endtask

    task automatic t_turn_on();
        align_idle();
        cmd_req = 1'b1;
        step(3);
        chk("R3", "gate still off after 3 edges", gate_on, 1'b0);
        step(1);
        chk("R3", "gate on after 4 edges", gate_on, 1'b1);
    endtask

    task automatic t_turn_off();
        align_idle();
        cmd_req = 1'b0;
        step(3);
        chk("R3", "gate still on after 3 edges", gate_on, 1'b1);
        step(1);
        chk("R3", "gate off after 4 edges", gate_on, 1'b0);
    endtask

    task automatic t_lost_on();
        align_idle();
        cmd_req = 1'b1;
        kill = 1'b1;
        step(4);
        kill = 1'b0;
        step(9);
        chk("R9", "gate off while turn-on symbol lost", gate_on, 1'b0);
        step(1);
        chk("R9", "gate on from refresh symbol", gate_on, 1'b1);
    endtask

    task automatic t_malformed();
        logic pat [6];
        pat = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
        align_idle();
        man_en = 1'b1;
        man_bit = 1'b0;
        step(1);
        for (int i = 1; i < 40; i++) begin
            man_bit = pat[(i - 1) % 6];
            step(1);
        end
        chk("R5", "malformed off symbol ignored", gate_on, 1'b1);
        chk("R5", "no timeout before 40 quiet edges", link_err, 1'b0);
        man_bit = pat[39 % 6];
        step(1);
        chk("R4", "link_err after 40 quiet edges", link_err, 1'b1);
        chk("R4", "gate forced off on timeout", gate_on, 1'b0);
        chk("R4", "ready low on timeout", ready, 1'b0);
    endtask

    task automatic t_recover();
        man_bit = 1'b0;
        step(2);
        send_sym(1'b1, 1'b1, 1'b0);
        chk("R7", "one good symbol does not clear", link_err, 1'b1);
        send_sym(1'b1, 1'b1, 1'b1);
        send_sym(1'b1, 1'b1, 1'b0);
        chk("R7", "count restarted by malformed symbol", link_err, 1'b1);
        send_sym(1'b1, 1'b1, 1'b0);
        chk("R7", "second consecutive good symbol clears", link_err, 1'b0);
        chk("R7", "gate follows command after clear", gate_on, 1'b1);
        align_idle();
        man_en = 1'b0;
    endtask

    task automatic t_supply();
        int ones;
        align_idle();
        supply_ok = 1'b0;
        #1;
        chk("R6", "ready drops with supply", ready, 1'b0);
        step(1);
        chk("R6", "farewell start", link_tx, 1'b1);
        step(1);
        chk("R6", "farewell command is off", link_tx, 1'b0);
        step(2);
        chk("R6", "gate off after farewell", gate_on, 1'b0);
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (link_tx) ones++;
        end
        chk("R6", "line silent while supply low", 1'(ones == 0), 1'b1);
        supply_ok = 1'b1;
        step(1);
        chk("R6", "symbol on supply return", link_tx, 1'b1);
        step(30);
        chk("R6", "ready back after supply return", ready, 1'b1);
        chk("R6", "gate back on after supply return", gate_on, 1'b1);
    endtask

    initial begin
        t_reset();
        t_linkup();
        t_frame();
        t_turn_on();
        t_turn_off();
        t_lost_on();
        t_malformed();
        t_recover();
        t_supply();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule